// File: doc/BRIEF.md
# Streaming Residue-and-Quotient Test Code Generator

This block takes the pixel pairs of one square block as a stream and produces two check codes for that block's sum of absolute differences (SAD). One code is the residue of the SAD modulo a fixed modulus m. The other is its quotient. The SAD itself is never formed.

Each accepted pair gives an absolute difference, which is split at once into an element quotient and an element residue. Element residues go into a running residue held in [0, m−1]. Each time that running residue passes m it wraps, and a carry goes into a running quotient. Element quotients also go into the running quotient.

When the final pair of a block is accepted, both codes are registered and a one-cycle done strobe is raised. A checker elsewhere can then compare them with the codes taken from a processing element's own SAD result.

Top module: `rq_code_gen`

## Requirements
- R1: While reset (active-low, synchronous) is applied and in the cycle after it is released, out_done is 0 and out_rt and out_qt are 0.
- R2: The difference is symmetric, d = |cur_pix − ref_pix|. A block made of a single pair (in_sob and in_last both 1) reports out_rt = d mod m and out_qt = floor(d / m). With m = 255 this gives d = 255 → out_rt 0, out_qt 1, and d = 254 → out_rt 254, out_qt 0.
- R3: For a block, out_rt equals the sum of the element residues reduced modulo m, which is the block SAD modulo m.
- R4: For a block, out_qt equals the sum of the element quotients plus floor(sum of element residues / m). Therefore out_qt·m + out_rt equals the block SAD.
- R5: The running residue never leaves [0, m−1], and every reported out_rt is below m.
- R6: A pair accepted with in_sob = 1 starts a new block. Sums left by earlier pairs are discarded, and the start pair itself counts.
- R7: out_done is 1 for exactly one cycle: the cycle after the clock edge that accepts a pair with in_last = 1. out_rt and out_qt change only at that edge and hold their values until the next such edge.
- R8: In cycles where in_valid is 0, cur_pix, ref_pix, in_sob and in_last have no effect on the sums or the outputs.
- R9: A full N×N block in which every difference is 255 (N = 16, m = 255) reports out_qt = 256 and out_rt = 0. The quotient width holds this value without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A pixel pair is offered and accepted this cycle |
| in_sob | input | 1 | The accepted pair is the first of a block |
| in_last | input | 1 | The accepted pair is the final one of a block |
| cur_pix | input | PIX_W (8) | Current-frame pixel |
| ref_pix | input | PIX_W (8) | Reference-frame pixel |
| out_done | output | 1 | One-cycle strobe: block codes are ready |
| out_rt | output | R_W (8) | Residue code of the block SAD |
| out_qt | output | Q_W (10) | Quotient code of the block SAD |

## Verification
The assertions assume that every block opens with a pair that carries in_sob, and that no block runs past N×N accepted pairs. Under those two conditions the quotient sum cannot wrap, and the no-overflow property depends on them. The stimulus obeys both rules. Each block starts with in_sob on its first pair and has at most 256 pairs, and the one deliberate partial run is at most ten pairs before a new start. Idle cycles inside a block carry random pixels and random control bits, so the inputs that the gating should ignore really do toggle.

// File: rtl/rqc_pkg.sv
package rqc_pkg;

   // How an absolute difference is split into quotient and residue.
   typedef enum logic [1:0] {
      SPLIT_POW2,   // modulus is a power of two: bit slicing
      SPLIT_ONES,   // modulus is the all-ones pixel value: one compare
      SPLIT_DIV     // any other modulus: constant division
   } split_e;

   function automatic split_e pick_split(input int modv, input int pixw);
      if ((modv & (modv - 1)) == 0) return SPLIT_POW2;
      if (modv == (1 << pixw) - 1) return SPLIT_ONES;
      return SPLIT_DIV;
   endfunction

   // Bits needed to hold 0..maxv, at least one.
   function automatic int width_of(input longint maxv);
      int w;
      w = 1;
      while ((longint'(1) << w) <= maxv) w++;
      return w;
   endfunction

endpackage

// File: rtl/rqc_elem_split.sv
module rqc_elem_split #(
   parameter int PIX_W = 8,
   parameter int MOD   = 255,
   parameter int R_W   = 8,
   parameter int EQ_W  = 1
) (
   input  logic [PIX_W-1:0] cur_pix,
   input  logic [PIX_W-1:0] ref_pix,
   output logic [R_W-1:0]   e_res,
   output logic [EQ_W-1:0]  e_quo
);
   import rqc_pkg::*;

   localparam split_e KIND = pick_split(MOD, PIX_W);

   logic [PIX_W-1:0] diff;

   assign diff = (cur_pix >= ref_pix) ? (cur_pix - ref_pix) : (ref_pix - cur_pix);

   generate
      if (KIND == SPLIT_POW2) begin : g_pow2
         assign e_res = diff[R_W-1:0];
         assign e_quo = EQ_W'(diff >> R_W);
      end else if (KIND == SPLIT_ONES) begin : g_ones
         logic full;
         assign full  = &diff;
         assign e_quo = EQ_W'(full);
         assign e_res = full ? '0 : diff[R_W-1:0];
      end else begin : g_div
         assign e_quo = EQ_W'(diff / PIX_W'(MOD));
         assign e_res = R_W'(diff % PIX_W'(MOD));
      end
   endgenerate

   // R2: the split reconstructs the difference with a residue below m
   always_comb begin
      p_elem_split_r2: assert ((int'(e_quo) * MOD + int'(e_res) == int'(diff)) && (int'(e_res) < MOD))
         else $error("element split does not rebuild the difference");
   end

endmodule

// File: rtl/rqc_accum.sv
module rqc_accum #(
   parameter int MOD  = 255,
   parameter int R_W  = 8,
   parameter int EQ_W = 1,
   parameter int Q_W  = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_en,
   input  logic            acc_clr,
   input  logic [R_W-1:0]  r_in,
   input  logic [EQ_W-1:0] q_in,
   output logic [R_W-1:0]  r_next,
   output logic [Q_W-1:0]  q_next
);

   logic [R_W-1:0] racc;
   logic [Q_W-1:0] qacc;
   logic [R_W-1:0] r_base;
   logic [Q_W-1:0] q_base;
   logic [R_W:0]   r_sum;
   logic           wrap;

   assign r_base = acc_clr ? '0 : racc;
   assign q_base = acc_clr ? '0 : qacc;
   assign r_sum  = {1'b0, r_base} + {1'b0, r_in};
   assign wrap   = (r_sum >= (R_W+1)'(MOD));
   assign r_next = wrap ? R_W'(r_sum - (R_W+1)'(MOD)) : r_sum[R_W-1:0];
   assign q_next = q_base + Q_W'(q_in) + Q_W'(wrap);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         racc <= '0;
         qacc <= '0;
      end else if (acc_en) begin
         racc <= r_next;
         qacc <= q_next;
      end
   end

   // R5: running residue stays inside [0, m-1]
   p_racc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(racc) < MOD);

   // R4: the quotient sum never wraps within a legal block
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |-> (q_next >= q_base));

endmodule

// File: rtl/rq_code_gen.sv
module rq_code_gen #(
   parameter int PIX_W = 8,
   parameter int BLK_N = 16,
   parameter int MOD   = 255,
   localparam int R_W  = rqc_pkg::width_of(longint'(MOD - 1)),
   localparam int EQ_W = rqc_pkg::width_of(longint'(((1 << PIX_W) - 1) / MOD)),
   localparam int Q_W  = rqc_pkg::width_of(longint'(BLK_N) * BLK_N * ((1 << PIX_W) - 1) / MOD) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sob,
   input  logic             in_last,
   input  logic [PIX_W-1:0] cur_pix,
   input  logic [PIX_W-1:0] ref_pix,
   output logic             out_done,
   output logic [R_W-1:0]   out_rt,
   output logic [Q_W-1:0]   out_qt
);

   initial begin
      p_cfg_mod_r2: assert (MOD >= 2 && MOD <= (1 << PIX_W) - 1)
         else $error("modulus must lie in [2, 2^PIX_W - 1]");
      p_cfg_blk_r9: assert (BLK_N >= 1 && PIX_W >= 2)
         else $error("block size and pixel width must be positive");
   end

   logic [R_W-1:0]  e_res;
   logic [EQ_W-1:0] e_quo;
   logic [R_W-1:0]  r_next;
   logic [Q_W-1:0]  q_next;
   logic            take_last;

   assign take_last = in_valid && in_last;

   rqc_elem_split #(
      .PIX_W (PIX_W),
      .MOD   (MOD),
      .R_W   (R_W),
      .EQ_W  (EQ_W)
   ) u_split (
      .cur_pix (cur_pix),
      .ref_pix (ref_pix),
      .e_res   (e_res),
      .e_quo   (e_quo)
   );

   rqc_accum #(
      .MOD  (MOD),
      .R_W  (R_W),
      .EQ_W (EQ_W),
      .Q_W  (Q_W)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_en  (in_valid),
      .acc_clr (in_sob),
      .r_in    (e_res),
      .q_in    (e_quo),
      .r_next  (r_next),
      .q_next  (q_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_done <= 1'b0;
         out_rt   <= '0;
         out_qt   <= '0;
      end else begin
         out_done <= take_last;
         if (take_last) begin
            out_rt <= r_next;
            out_qt <= q_next;
         end
      end
   end

   // R7: done only follows an accepted last pair
   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> $past(take_last));

   // R7: results hold between block ends
   p_hold_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !take_last |=> ($stable(out_rt) && $stable(out_qt)));

   // R8: an idle cycle never raises done
   p_idle_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_done);

   // R5: reported residue below the modulus
   p_rt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (int'(out_rt) < MOD));

endmodule

// File: tb/rq_code_gen_test.sv
module rq_code_gen_test;
   localparam int CLK_P = 10;
   localparam int PIX_W = 8;
   localparam int BLK_N = 16;
   localparam int MOD   = 255;
   localparam int NPIX  = BLK_N * BLK_N;
   localparam int QW    = 10;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid, in_sob, in_last;
   logic [PIX_W-1:0] cur_pix, ref_pix;
   logic             out_done;
   logic [7:0]       out_rt;
   logic [QW-1:0]    out_qt;

   rq_code_gen #(.PIX_W(PIX_W), .BLK_N(BLK_N), .MOD(MOD)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob),
      .in_last(in_last), .cur_pix(cur_pix), .ref_pix(ref_pix),
      .out_done(out_done), .out_rt(out_rt), .out_qt(out_qt));

   always #(CLK_P/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;
   int cpx [NPIX];
   int rpx [NPIX];

   task automatic check(input string req, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int absd(input int a, input int b);
      return (a >= b) ? a - b : b - a;
   endfunction

   function automatic longint ref_sad(input int n);
      longint s = 0;
      for (int i = 0; i < n; i++) s += absd(cpx[i], rpx[i]);
      return s;
   endfunction

   task automatic idle_garbage();
      @(negedge clk);
      in_valid = 1'b0;
      cur_pix  = PIX_W'($urandom);
      ref_pix  = PIX_W'($urandom);
      in_sob   = 1'($urandom);
      in_last  = 1'($urandom);
   endtask

   // Streams pairs 0..n-1 as one block, optionally with idle gaps (R8).
   task automatic play(input int n, input bit gaps, input string tag);
      longint sad;
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom_range(0, 2) == 0)) idle_garbage();
         @(negedge clk);
         if (i == n - 1) check({tag, " R7 done low before end"}, out_done, 0);
         in_valid = 1'b1;
         cur_pix  = PIX_W'(cpx[i]);
         ref_pix  = PIX_W'(rpx[i]);
         in_sob   = (i == 0);
         in_last  = (i == n - 1);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sob = 1'b0; in_last = 1'b0;
      sad = ref_sad(n);
      check({tag, " R7 done"}, out_done, 1);
      check({tag, " R3 rt"}, out_rt, sad % MOD);
      check({tag, " R4 qt"}, out_qt, sad / MOD);
      check({tag, " R4 rt+qt*m"}, longint'(out_rt) + longint'(out_qt) * MOD, sad);
      check({tag, " R5 rt<m"}, (out_rt < MOD), 1);
      @(negedge clk);
      check({tag, " R7 one-cycle done"}, out_done, 0);
      check({tag, " R7 hold rt"}, out_rt, sad % MOD);
      check({tag, " R7 hold qt"}, out_qt, sad / MOD);
   endtask

   task automatic single(input int c, input int r);
      int d;
      cpx[0] = c; rpx[0] = r;
      d = absd(c, r);
      @(negedge clk);
      in_valid = 1'b1; in_sob = 1'b1; in_last = 1'b1;
      cur_pix = PIX_W'(c); ref_pix = PIX_W'(r);
      @(negedge clk);
      in_valid = 1'b0; in_sob = 1'b0; in_last = 1'b0;
      check("R2 single rt", out_rt, d % MOD);
      check("R2 single qt", out_qt, d / MOD);
   endtask

   initial begin
      void'($urandom(32'd7341));
      rst_n = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_last = 1'b0;
      cur_pix = '0; ref_pix = '0;
      repeat (3) @(negedge clk);
      check("R1 reset done", out_done, 0);
      check("R1 reset rt", out_rt, 0);
      check("R1 reset qt", out_qt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release done", out_done, 0);
      check("R1 after release qt", out_qt, 0);

      // R2: directed single-pair blocks, both orders
      single(255, 0);
      single(0, 255);
      single(254, 0);
      single(0, 254);
      single(3, 200);
      single(200, 3);
      single(77, 77);
      single(1, 0);

      // R9: every difference at the top of the range
      for (int i = 0; i < NPIX; i++) begin cpx[i] = 255; rpx[i] = 0; end
      play(NPIX, 0, "max block");
      check("R9 qt 256", out_qt, 256);
      check("R9 rt 0", out_rt, 0);

      // zero block
      for (int i = 0; i < NPIX; i++) begin cpx[i] = 42; rpx[i] = 42; end
      play(NPIX, 0, "zero block");

      // random blocks, some with idle gaps carrying garbage (R8)
      for (int b = 0; b < 10; b++) begin
         for (int i = 0; i < NPIX; i++) begin
            cpx[i] = $urandom_range(0, 255);
            rpx[i] = $urandom_range(0, 255);
         end
         play(NPIX, b[0], b[0] ? "R8 gapped random" : "random");
      end

      // reference always above current, differences near the modulus
      for (int i = 0; i < NPIX; i++) begin
         cpx[i] = $urandom_range(0, 3);
         rpx[i] = $urandom_range(250, 255);
      end
      play(NPIX, 1, "ref-high");

      // R6: partial run without an end, then a fresh block must drop it
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sob = (i == 0); in_last = 1'b0;
         cur_pix = 8'd250; ref_pix = 8'd1;
      end
      for (int i = 0; i < 37; i++) begin
         cpx[i] = $urandom_range(0, 255);
         rpx[i] = $urandom_range(0, 255);
      end
      play(37, 1, "R6 restart");

      // short blocks of varying length
      for (int b = 0; b < 4; b++) begin
         for (int i = 0; i < 2 + b * 5; i++) begin
            cpx[i] = $urandom_range(0, 255);
            rpx[i] = $urandom_range(0, 255);
         end
         play(2 + b * 5, 1, "short");
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule